// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a watchdog for a system controller. Software programs a reload value, then enables the timer through a control register. A 32-bit down-counter then counts towards zero, at one count per peripheral-clock cycle or at one count per microsecond. To keep the system alive, software must periodically write a fixed 16-bit key to the restart register. If the counter reaches zero, the block drives a timed reset request whose polarity is programmable. The exception is when the memory controller is itself being held in reset: then the expiry only disarms the watchdog.

The bus side is a plain synchronous register port. A write takes effect on the clock edge where `bus_we` is high. Read data is combinational from `bus_addr` and the current state. There is no stream interface, so no valid/ready handshake exists. Every access is accepted in a single cycle, and nothing can stall. Only word-aligned byte addresses decode.

The peripheral clock `clk` is nominally 24 MHz. A free-running divide-by-24 prescaler supplies the microsecond tick, which is used both for counting and for timing the reset pulse.

Top module: `wdog_ctrl`

## Requirements
- R1: Right after reset, these registers read as follows:
  - count (0x00) and reload (0x04) both read 0x03EF1480;
  - control (0x0C) reads 0;
  - pulse setup (0x18) reads 0x000000FF;
  - spare (0x1C) reads 0.
  Also right after reset, `rst_req_o` is 1 (active-low, idle) and `drive_pp_o` is 0.
- R2: Read and write rules by address:
  - Reads of 0x08, 0x10, 0x14, of any other unmapped address, or of any address with bits 1:0 non-zero, return 0.
  - Writes to 0x00, 0x10 and 0x14 change nothing.
  - Writes to addresses with bits 1:0 non-zero change nothing.
- R3: A write to 0x08 acts only when its bits 15:0 equal 0x4755. It then copies reload into count and, if control bit 0 is set, resumes counting (also after an expiry). Any other value has no effect.
- R4: Control bits 6:0 are stored, and bits 31:7 read 0. The bit meanings are:
  - bit 0: enable;
  - bit 1: system reset;
  - bit 2: interrupt;
  - bit 3: external signal;
  - bit 4: tick select, where 1 is the microsecond tick;
  - bits 6:5: reset scope.
  A control write is stored only when its bit 0 differs from the stored bit 0. Any other control write is ignored.
- R5: Changes of the enable bit:
  - A 0-to-1 change of enable loads count from reload.
  - After that, count falls by one per selected tick.
  - A 1-to-0 change freezes count.
- R6: With control bit 4 clear, count falls by one every `clk` cycle.
- R7: With control bit 4 set, count falls by one every 24 `clk` cycles, on a prescaler that runs from reset. Any 48 consecutive cycles hold exactly two ticks.
- R8: Expiry happens on the tick taken while count is 1 or 0. Count then reads 0 and counting stops. Enable stays set.
- R9: On expiry, a reset pulse is driven on `rst_req_o`:
  - The pulse lasts the value of setup bits 19:0, counted in microsecond ticks. It therefore stays active for between (N-1)*24+1 and N*24 cycles, where N is that value.
  - If setup bit 31 is 1, the pulse is high; if bit 31 is 0, the pulse is low.
  - A value of 0 gives no pulse.
- R10: If `mem_rst_i` is high at expiry, no pulse is issued and control is cleared to 0.
- R11: A write to 0x18 copies bits 19:0 into the pulse-length field. Bits 31:24 act as a key:
  - 0xA5 sets bit 31;
  - 0x5A clears bit 31;
  - 0xA8 sets bit 30;
  - 0x8A clears bit 30;
  - any other key value leaves bits 31:30 unchanged.
  Bits 29:20 read 0. `drive_pp_o` follows bit 30.
- R12: Register 0x1C is plain 32-bit read/write storage with no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock (24 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_we | input | 1 | Write strobe, acts on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| mem_rst_i | input | 1 | High while the memory controller is in reset |
| rst_req_o | output | 1 | Reset request, polarity from setup bit 31 |
| drive_pp_o | output | 1 | Drive type for the reset pad, 1 = push-pull |

## Verification
The countdown is run in both tick modes.
- In peripheral-clock mode, successive reads must differ by exactly one. This separates a per-cycle decrement from a per-microsecond one.
- In microsecond mode, a 48-cycle window must show exactly two decrements. This catches a prescaler that is off by one.

Control writes are tried in three forms: with enable unchanged, with enable rising, and with enable falling. This distinguishes a stored control value from an ignored one.

Restart writes are tried with a wrong key, with the right key while disabled, and with the right key after an expiry. These cases separate reloading from re-arming.

Expiries are forced with `mem_rst_i` high, with a zero pulse length, and under both polarities. These cases tell suppression, pulse length and output inversion apart.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] OFF_COUNT   = 8'h00;
  localparam logic [7:0] OFF_RELOAD  = 8'h04;
  localparam logic [7:0] OFF_RESTART = 8'h08;
  localparam logic [7:0] OFF_CTRL    = 8'h0C;
  localparam logic [7:0] OFF_SETUP   = 8'h18;
  localparam logic [7:0] OFF_SPARE   = 8'h1C;

  localparam logic [15:0] RESTART_KEY = 16'h4755;
  localparam logic [7:0]  KEY_POL_HI  = 8'hA5;
  localparam logic [7:0]  KEY_POL_LO  = 8'h5A;
  localparam logic [7:0]  KEY_PP_ON   = 8'hA8;
  localparam logic [7:0]  KEY_PP_OFF  = 8'h8A;

  localparam int CTRL_W   = 7;
  localparam int CB_EN    = 0;
  localparam int CB_TSEL  = 4;

  typedef struct packed {
    logic en_rise;
    logic en_fall;
    logic restart;
  } wd_evt_t;
endpackage

// File: rtl/wdog_tick.sv
module wdog_tick #(
  parameter int PRESCALE = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_us_i,
  output logic us_tick_o,
  output logic cnt_tick_o
);
  generate
    if (PRESCALE > 1) begin : g_div
      localparam int PW = $clog2(PRESCALE);
      logic [PW-1:0] pre;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         pre <= '0;
        else if (us_tick_o) pre <= '0;
        else                pre <= pre + 1'b1;
      end

      assign us_tick_o = (pre == PW'(PRESCALE - 1));

      p_tick_sparse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        us_tick_o |=> !us_tick_o)
        else $error("microsecond tick on consecutive cycles");
    end else begin : g_pass
      assign us_tick_o = 1'b1;
    end
  endgenerate

  assign cnt_tick_o = sel_us_i ? us_tick_o : 1'b1;
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs import wdog_pkg::*; #(
  parameter int              ADDR_W   = 8,
  parameter int              DATA_W   = 32,
  parameter int              PW_W     = 20,
  parameter logic [DATA_W-1:0] CNT_INIT = 32'h03EF1480,
  parameter logic [PW_W-1:0]   PW_INIT  = 20'h000FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              exp_clr_i,
  output logic              ctrl_en_o,
  output logic              tick_us_o,
  output logic [DATA_W-1:0] reload_o,
  output logic [PW_W-1:0]   pw_o,
  output logic              pol_hi_o,
  output logic              push_pull_o,
  output wd_evt_t           evt_o
);
  localparam int PAD_W = DATA_W - 2 - PW_W;

  logic              aligned, wr;
  logic              hit_reload, hit_restart, hit_ctrl, hit_setup, hit_spare;
  logic [CTRL_W-1:0] ctrl;
  logic [DATA_W-1:0] spare;
  logic [7:0]        key;

  assign aligned     = (bus_addr[1:0] == 2'b00);
  assign wr          = bus_we && aligned;
  assign hit_reload  = (bus_addr == ADDR_W'(OFF_RELOAD));
  assign hit_restart = (bus_addr == ADDR_W'(OFF_RESTART));
  assign hit_ctrl    = (bus_addr == ADDR_W'(OFF_CTRL));
  assign hit_setup   = (bus_addr == ADDR_W'(OFF_SETUP));
  assign hit_spare   = (bus_addr == ADDR_W'(OFF_SPARE));
  assign key         = bus_wdata[DATA_W-1 -: 8];

  always_comb begin
    evt_o.en_rise = wr && hit_ctrl &&  bus_wdata[CB_EN] && !ctrl[CB_EN];
    evt_o.en_fall = wr && hit_ctrl && !bus_wdata[CB_EN] &&  ctrl[CB_EN];
    evt_o.restart = wr && hit_restart && (bus_wdata[15:0] == RESTART_KEY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_o    <= CNT_INIT;
      ctrl        <= '0;
      pw_o        <= PW_INIT;
      pol_hi_o    <= 1'b0;
      push_pull_o <= 1'b0;
      spare       <= '0;
    end else begin
      if (wr && hit_reload) reload_o <= bus_wdata;
      if (wr && hit_spare)  spare    <= bus_wdata;
      if (exp_clr_i)                            ctrl <= '0;
      else if (evt_o.en_rise || evt_o.en_fall)  ctrl <= bus_wdata[CTRL_W-1:0];
      if (wr && hit_setup) begin
        pw_o <= bus_wdata[PW_W-1:0];
        case (key)
          KEY_POL_HI: pol_hi_o    <= 1'b1;
          KEY_POL_LO: pol_hi_o    <= 1'b0;
          KEY_PP_ON:  push_pull_o <= 1'b1;
          KEY_PP_OFF: push_pull_o <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  assign ctrl_en_o = ctrl[CB_EN];
  assign tick_us_o = ctrl[CB_TSEL];

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      if (bus_addr == ADDR_W'(OFF_COUNT)) bus_rdata = cnt_i;
      if (hit_reload) bus_rdata = reload_o;
      if (hit_ctrl)   bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
      if (hit_setup)  bus_rdata = {pol_hi_o, push_pull_o, {PAD_W{1'b0}}, pw_o};
      if (hit_spare)  bus_rdata = spare;
    end
  end

  p_ctrl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_ctrl && (bus_wdata[CB_EN] == ctrl[CB_EN]) && !exp_clr_i) |=> $stable(ctrl))
    else $error("control changed without an enable toggle");
endmodule

// File: rtl/wdog_core.sv
module wdog_core import wdog_pkg::*; #(
  parameter int              DATA_W   = 32,
  parameter int              PW_W     = 20,
  parameter logic [DATA_W-1:0] CNT_INIT = 32'h03EF1480
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wd_evt_t           evt_i,
  input  logic              ctrl_en_i,
  input  logic              cnt_tick_i,
  input  logic              us_tick_i,
  input  logic [DATA_W-1:0] reload_i,
  input  logic              mem_rst_i,
  input  logic [PW_W-1:0]   pw_i,
  input  logic              pol_hi_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              exp_clr_o,
  output logic              rst_req_o
);
  logic            run, load, expire, pulse_on;
  logic [PW_W-1:0] pulse;

  assign load   = evt_i.en_rise || evt_i.restart;
  assign expire = !evt_i.en_fall && !load && run && cnt_tick_i &&
                  (cnt_o <= DATA_W'(1));
  assign exp_clr_o = expire && mem_rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= CNT_INIT;
      run   <= 1'b0;
    end else if (evt_i.en_fall) begin
      run   <= 1'b0;
    end else if (load) begin
      cnt_o <= reload_i;
      run   <= evt_i.en_rise || ctrl_en_i;
    end else if (expire) begin
      cnt_o <= '0;
      run   <= 1'b0;
    end else if (run && cnt_tick_i) begin
      cnt_o <= cnt_o - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pulse <= '0;
    else if (expire && !mem_rst_i)       pulse <= pw_i;
    else if (pulse_on && us_tick_i)      pulse <= pulse - 1'b1;
  end

  assign pulse_on  = (pulse != '0);
  assign rst_req_o = pol_hi_i ? pulse_on : !pulse_on;

  p_run_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ctrl_en_i)
    else $error("counting while disabled");

  p_cnt_down_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load) |=> (cnt_o <= $past(cnt_o)))
    else $error("count rose without a reload");

  p_stop_at_expiry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (!run && cnt_o == '0))
    else $error("counter still running after expiry");

  p_no_pulse_memrst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && mem_rst_i && !pulse_on) |=> !pulse_on)
    else $error("reset pulse issued during memory reset");
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl import wdog_pkg::*; #(
  parameter int              ADDR_W   = 8,
  parameter int              DATA_W   = 32,
  parameter int              PW_W     = 20,
  parameter int              PRESCALE = 24,
  parameter logic [DATA_W-1:0] CNT_INIT = 32'h03EF1480
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              mem_rst_i,
  output logic              rst_req_o,
  output logic              drive_pp_o
);
  logic              ctrl_en, tick_us, us_tick, cnt_tick, exp_clr, pol_hi;
  logic [DATA_W-1:0] cnt, reload;
  logic [PW_W-1:0]   pw;
  wd_evt_t           evt;

  wdog_tick #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .sel_us_i(tick_us),
    .us_tick_o(us_tick), .cnt_tick_o(cnt_tick)
  );

  wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PW_W(PW_W), .CNT_INIT(CNT_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_i(cnt),
    .exp_clr_i(exp_clr), .ctrl_en_o(ctrl_en), .tick_us_o(tick_us),
    .reload_o(reload), .pw_o(pw), .pol_hi_o(pol_hi),
    .push_pull_o(drive_pp_o), .evt_o(evt)
  );

  wdog_core #(.DATA_W(DATA_W), .PW_W(PW_W), .CNT_INIT(CNT_INIT)) u_core (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .ctrl_en_i(ctrl_en),
    .cnt_tick_i(cnt_tick), .us_tick_i(us_tick), .reload_i(reload),
    .mem_rst_i(mem_rst_i), .pw_i(pw), .pol_hi_i(pol_hi),
    .cnt_o(cnt), .exp_clr_o(exp_clr), .rst_req_o(rst_req_o)
  );
endmodule

// File: tb/sim_wdog_ctrl.sv
`timescale 1ns/100ps
module sim_wdog_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mem_rst_i = 1'b0;
  logic        rst_req_o, drive_pp_o;

  int n_tests = 0;
  int n_fail  = 0;
  int hi_cyc  = 0;
  int lo_cyc  = 0;
  bit done    = 0;

  // behavioural reference state
  logic [31:0] m_cnt, m_reload, m_spare, m_setup;
  logic [6:0]  m_ctrl;
  logic        m_run;
  int          m_pulse;
  longint      m_edge;

  always #2 clk = ~clk;

  wdog_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mem_rst_i(mem_rst_i),
    .rst_req_o(rst_req_o), .drive_pp_o(drive_pp_o)
  );

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    case (a)
      8'h00: return m_cnt;
      8'h04: return m_reload;
      8'h0C: return {25'h0, m_ctrl};
      8'h18: return m_setup;
      8'h1C: return m_spare;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 32'h03EF1480; m_reload = 32'h03EF1480; m_spare = 0;
      m_setup = 32'h000000FF; m_ctrl = 0; m_run = 0; m_pulse = 0; m_edge = 0;
    end else begin
      logic tu, tk, wr, rise, fall, rs, ex;
      tu = ((m_edge % 24) == 23);
      m_edge++;
      tk = m_ctrl[4] ? tu : 1'b1;
      wr = bus_we && (bus_addr[1:0] == 2'b00);
      rise = wr && bus_addr == 8'h0C && bus_wdata[0] && !m_ctrl[0];
      fall = wr && bus_addr == 8'h0C && !bus_wdata[0] && m_ctrl[0];
      rs = wr && bus_addr == 8'h08 && bus_wdata[15:0] == 16'h4755;
      ex = 0;
      if (fall) m_run = 0;
      else if (rise || rs) begin m_cnt = m_reload; m_run = rise || m_ctrl[0]; end
      else if (m_run && tk) begin
        if (m_cnt <= 1) begin m_cnt = 0; m_run = 0; ex = 1; end
        else m_cnt = m_cnt - 1;
      end
      if (ex && !mem_rst_i) m_pulse = int'(m_setup[19:0]);
      else if (m_pulse != 0 && tu) m_pulse--;
      if (ex && mem_rst_i) m_ctrl = 0;
      else if (rise || fall) m_ctrl = bus_wdata[6:0];
      if (wr && bus_addr == 8'h04) m_reload = bus_wdata;
      if (wr && bus_addr == 8'h1C) m_spare = bus_wdata;
      if (wr && bus_addr == 8'h18) begin
        m_setup[19:0] = bus_wdata[19:0];
        case (bus_wdata[31:24])
          8'hA5: m_setup[31] = 1'b1;
          8'h5A: m_setup[31] = 1'b0;
          8'hA8: m_setup[30] = 1'b1;
          8'h8A: m_setup[30] = 1'b0;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic exp_rst;
      exp_rst = m_setup[31] ? (m_pulse != 0) : (m_pulse == 0);
      chk("R2 rdata vs model", bus_rdata, m_read(bus_addr));
      chk("R9 rst_req_o vs model", {31'h0, rst_req_o}, {31'h0, exp_rst});
      chk("R11 drive_pp_o vs model", {31'h0, drive_pp_o}, {31'h0, m_setup[30]});
      if (rst_req_o) hi_cyc++; else lo_cyc++;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, v1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(8'h00, v); chk("R1 count", v, 32'h03EF1480);
    rd(8'h04, v); chk("R1 reload", v, 32'h03EF1480);
    rd(8'h0C, v); chk("R1 control", v, 32'h0);
    rd(8'h18, v); chk("R1 setup", v, 32'h000000FF);
    rd(8'h1C, v); chk("R1 spare", v, 32'h0);
    chk("R1 rst_req idle", {31'h0, rst_req_o}, 32'h1);
    chk("R1 drive_pp", {31'h0, drive_pp_o}, 32'h0);

    // R2 map rules
    wr(8'h00, 32'h12345678); rd(8'h00, v); chk("R2 count write ignored", v, 32'h03EF1480);
    rd(8'h08, v); chk("R2 restart reads 0", v, 32'h0);
    wr(8'h10, 32'hFFFFFFFF); rd(8'h10, v); chk("R2 0x10 zero", v, 32'h0);
    rd(8'h14, v); chk("R2 0x14 zero", v, 32'h0);
    rd(8'h40, v); chk("R2 unmapped zero", v, 32'h0);
    wr(8'h05, 32'h0000FFFF); rd(8'h05, v); chk("R2 unaligned read", v, 32'h0);
    rd(8'h04, v); chk("R2 unaligned write ignored", v, 32'h03EF1480);

    // R12 spare storage
    wr(8'h1C, 32'hDEADBEEF); rd(8'h1C, v); chk("R12 spare rw", v, 32'hDEADBEEF);
    chk("R12 no output effect", {31'h0, rst_req_o}, 32'h1);

    // R11 keyed setup
    wr(8'h18, 32'hA5012345); rd(8'h18, v); chk("R11 pol key", v, 32'h80012345);
    chk("R11 active-high idle", {31'h0, rst_req_o}, 32'h0);
    wr(8'h18, 32'hA8000010); rd(8'h18, v); chk("R11 pp key", v, 32'hC0000010);
    chk("R11 drive_pp set", {31'h0, drive_pp_o}, 32'h1);
    wr(8'h18, 32'h33F00020); rd(8'h18, v); chk("R11 other key", v, 32'hC0000020);
    wr(8'h18, 32'h8A000020); rd(8'h18, v); chk("R11 od key", v, 32'h80000020);
    wr(8'h18, 32'h5A000003); rd(8'h18, v); chk("R11 pol low key", v, 32'h00000003);
    wr(8'h18, 32'hA5000003); rd(8'h18, v); chk("R11 pol high again", v, 32'h80000003);

    // R4 ignored control write
    wr(8'h0C, 32'hFFFFFF7E); rd(8'h0C, v); chk("R4 no toggle ignored", v, 32'h0);

    // R5 R6 peripheral-clock countdown
    wr(8'h04, 32'd10);
    wr(8'h0C, 32'hFFFFFF83);
    rd(8'h00, v); chk("R6 first decrement", v, 32'd9);
    rd(8'h00, v); chk("R6 second decrement", v, 32'd8);
    rd(8'h0C, v); chk("R4 stored bits 6:0", v, 32'h03);
    wr(8'h0C, 32'h13); rd(8'h0C, v); chk("R4 enable unchanged ignored", v, 32'h03);

    // R8 R9 expiry and pulse (3 us, active high)
    idle(15); hi_cyc = 0;
    rd(8'h00, v); chk("R8 count zero", v, 32'h0);
    chk("R9 pulse active", {31'h0, rst_req_o}, 32'h1);
    rd(8'h0C, v); chk("R8 enable kept", v, 32'h03);
    idle(90);
    chk("R9 pulse ended", {31'h0, rst_req_o}, 32'h0);

    // R3 keyed restart
    wr(8'h08, 32'h00001234); rd(8'h00, v); chk("R3 wrong key", v, 32'h0);
    wr(8'h08, 32'hABCD4755); rd(8'h00, v); chk("R3 rearm after expiry", v, 32'd9);

    // R5 disable freezes
    wr(8'h0C, 32'h02); rd(8'h00, v); idle(5); rd(8'h00, v1);
    chk("R5 frozen when disabled", v1, v);
    wr(8'h08, 32'h4755); rd(8'h00, v); chk("R3 reload while disabled", v, 32'd10);
    idle(5); rd(8'h00, v); chk("R3 no count while disabled", v, 32'd10);

    // R7 microsecond mode
    wr(8'h04, 32'd3);
    wr(8'h0C, 32'h11);
    rd(8'h00, v);
    n_tests++;
    if (v != 32'd3 && v != 32'd2) begin
      n_fail++; $display("FAIL R7 start: got %0d expected 2 or 3", v);
    end
    idle(47); rd(8'h00, v1); chk("R7 two ticks in 48 cycles", v1, v - 32'd2);
    hi_cyc = 0;
    idle(150);
    n_tests++;
    if (hi_cyc < 49 || hi_cyc > 72) begin
      n_fail++; $display("FAIL R9 pulse length: got %0d expected 49..72", hi_cyc);
    end
    rd(8'h00, v); chk("R8 count zero in us mode", v, 32'h0);

    // R10 memory reset suppresses expiry
    wr(8'h0C, 32'h10); wr(8'h04, 32'd5);
    @(negedge clk); mem_rst_i = 1'b1;
    hi_cyc = 0;
    wr(8'h0C, 32'h01); idle(20);
    chk("R10 no pulse", hi_cyc, 0);
    rd(8'h0C, v); chk("R10 control cleared", v, 32'h0);
    rd(8'h00, v); chk("R10 count zero", v, 32'h0);
    @(negedge clk); mem_rst_i = 1'b0;

    // R9 zero-length pulse
    wr(8'h18, 32'hA5000000); wr(8'h04, 32'd2);
    hi_cyc = 0;
    wr(8'h0C, 32'h01); idle(30);
    chk("R9 zero width no pulse", hi_cyc, 0);

    // R9 active-low single-us pulse
    wr(8'h18, 32'h5A000001);
    chk("R9 active-low idle", {31'h0, rst_req_o}, 32'h1);
    lo_cyc = 0;
    wr(8'h08, 32'h4755); idle(40);
    n_tests++;
    if (lo_cyc < 1 || lo_cyc > 24) begin
      n_fail++; $display("FAIL R9 low pulse: got %0d expected 1..24", lo_cyc);
    end
    chk("R9 low pulse over", {31'h0, rst_req_o}, 32'h1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule